// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits on the host side of a parallel NOR-flash style memory. It accepts one high-level request and plays it out as a series of one to six bus cycles. The supported requests are program, chip erase, sector erase, bypass enter, bypass program, bypass exit, reset, suspend, resume and an identification read. Each cycle drives an address and a data word, and holds the chip enable low. It then strobes the write enable low, or the output enable low for the single read cycle. A parameterised number of clocks is spent before, during and after the strobe.

The unlock cycles that open most sequences use two fixed addresses. A width-mode input picks the pair. Once the bypass mode has been entered, the short bypass-program request skips the unlock cycles. The identification request ends with a read cycle, and the data returned by that read is kept on an output. A one-clock done pulse marks the end of every sequence. Status polling after program or erase is left to the caller.

Top module: `flash_cmd_seq`

## Requirements
- R1: While reset is held, and after it is released, fl_ce_n, fl_we_n and fl_oe_n are high, done is low, req_ready is high, and fl_addr and fl_dout are zero.
- R2: Request code 1 (program) produces four writes: 0xAA to the first unlock address, 0x55 to the second, 0xA0 to the first, then req_data to req_addr. Command bytes sit in the low 8 bits of fl_dout, and the upper bits are zero.
- R3: The first and second unlock addresses are 0xAAA and 0x555 when word_mode is 0, and 0x555 and 0x2AA when word_mode is 1. word_mode, req_addr and req_data are sampled only at acceptance.
- R4: Request code 2 (chip erase) produces six writes: 0xAA, 0x55, 0x80, 0xAA and 0x55 to first, second, first, first and second unlock addresses, then 0x10 to the first unlock address.
- R5: Request code 3 (sector erase) matches chip erase, except that its sixth write sends 0x30 to req_addr.
- R6: Request code 4 (bypass enter) writes 0xAA, 0x55 and 0x20 to first, second and first unlock addresses. Code 5 (bypass program) writes 0xA0 to address 0, then req_data to req_addr. Code 6 (bypass exit) writes 0x90 and then 0x00, both to address 0.
- R7: Codes 0 (reset), 7 (suspend) and 8 (resume) are one write each to address 0, with data 0xF0, 0xB0 and 0x30 respectively.
- R8: Code 9 (identify) writes 0xAA, 0x55 and 0x90 to first, second and first unlock addresses. It then performs a read at req_addr: fl_oe_n is low for the pulse clocks, fl_we_n stays high, and fl_drive is low. rd_data takes fl_din as sampled on the last pulse clock and holds it until the next read.
- R9: Every bus cycle has SETUP_CLKS clocks with fl_ce_n low and the strobes high, then PULSE_CLKS clocks with the strobe low, then HOLD_CLKS clocks with the strobes high. Cycles follow back to back with fl_ce_n low. fl_addr and fl_dout do not change within a cycle.
- R10: A request is taken only when req_valid is high, req_ready is high and req_op is 0 to 9. Requests while busy and codes 10 to 15 cause no bus activity.
- R11: done is high for exactly one clock, right after the last hold clock of a sequence. req_ready is high again in that same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 4 | Request code |
| req_addr | input | AW | Target, sector or identify offset address |
| req_data | input | DW | Data to program |
| word_mode | input | 1 | Selects the unlock address pair |
| req_ready | output | 1 | High when idle and able to accept |
| done | output | 1 | One-clock pulse at end of sequence |
| rd_data | output | DW | Data from the last identify read |
| fl_addr | output | AW | Flash address bus |
| fl_dout | output | DW | Data driven to the flash |
| fl_din | input | DW | Data returned by the flash |
| fl_drive | output | 1 | High when fl_dout should be driven onto the pins |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |

## Verification
The assertions watch the bus discipline on every clock. The two strobes are never low together. A write strobe only falls after chip enable has been low for a clock. Address and data stay put across a strobe and at its rising edge. The bus is released during reads. done is a single-clock pulse, and the idle bus is quiet. The cycle contents of each request can only be shown by the bench scenarios, which compare every clock against a queue-based model. Those contents are the command bytes, the unlock address pair picked by the width mode, the sector and target addresses, the identify read data, and the refusal of requests while busy or with unused codes.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [3:0] {
        OP_RESET        = 4'd0,
        OP_PROGRAM      = 4'd1,
        OP_CHIP_ERASE   = 4'd2,
        OP_SECTOR_ERASE = 4'd3,
        OP_BYP_ENTER    = 4'd4,
        OP_BYP_PROGRAM  = 4'd5,
        OP_BYP_EXIT     = 4'd6,
        OP_SUSPEND      = 4'd7,
        OP_RESUME       = 4'd8,
        OP_IDENTIFY     = 4'd9
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_PULSE,
        PH_HOLD
    } phase_e;

    localparam int MAX_STEPS = 6;
    localparam int STEP_W    = $clog2(MAX_STEPS);

    localparam logic [11:0] UNLOCK1_BYTE = 12'hAAA;
    localparam logic [11:0] UNLOCK2_BYTE = 12'h555;
    localparam logic [11:0] UNLOCK1_WORD = 12'h555;
    localparam logic [11:0] UNLOCK2_WORD = 12'h2AA;

    function automatic logic op_known(input logic [3:0] code);
        return code <= 4'd9;
    endfunction

endpackage

// File: rtl/flash_seq_table.sv
module flash_seq_table
    import flash_seq_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  op_e               op,
    input  logic [STEP_W-1:0] idx,
    input  logic              word_mode,
    input  logic [AW-1:0]     tgt_addr,
    input  logic [DW-1:0]     tgt_data,
    output logic [AW-1:0]     step_addr,
    output logic [DW-1:0]     step_data,
    output logic              step_read,
    output logic              step_last
);

    typedef enum logic [1:0] {AS_ZERO, AS_U1, AS_U2, AS_TGT} asel_e;

    typedef struct packed {
        asel_e      asel;
        logic [7:0] cmd;
        logic       use_tgt;
        logic       rd;
        logic       last;
    } ent_t;

    function automatic ent_t mk(input asel_e a, input logic [7:0] c,
                                input logic t, input logic r, input logic l);
        ent_t e;
        e.asel    = a;
        e.cmd     = c;
        e.use_tgt = t;
        e.rd      = r;
        e.last    = l;
        return e;
    endfunction

    localparam logic [AW-1:0] U1B = AW'(UNLOCK1_BYTE);
    localparam logic [AW-1:0] U2B = AW'(UNLOCK2_BYTE);
    localparam logic [AW-1:0] U1W = AW'(UNLOCK1_WORD);
    localparam logic [AW-1:0] U2W = AW'(UNLOCK2_WORD);

    ent_t ent;

    // Entry selection: opcode and step index give one bus cycle
    always_comb begin
        ent = mk(AS_ZERO, 8'h00, 1'b0, 1'b0, 1'b1);
        unique case (op)
            OP_RESET:   ent = mk(AS_ZERO, 8'hF0, 1'b0, 1'b0, 1'b1);
            OP_SUSPEND: ent = mk(AS_ZERO, 8'hB0, 1'b0, 1'b0, 1'b1);
            OP_RESUME:  ent = mk(AS_ZERO, 8'h30, 1'b0, 1'b0, 1'b1);
            OP_PROGRAM: begin
                case (idx)
                    3'd0:    ent = mk(AS_U1,  8'hAA, 1'b0, 1'b0, 1'b0);
                    3'd1:    ent = mk(AS_U2,  8'h55, 1'b0, 1'b0, 1'b0);
                    3'd2:    ent = mk(AS_U1,  8'hA0, 1'b0, 1'b0, 1'b0);
                    default: ent = mk(AS_TGT, 8'h00, 1'b1, 1'b0, 1'b1);
                endcase
            end
            OP_CHIP_ERASE, OP_SECTOR_ERASE: begin
                case (idx)
                    3'd0:    ent = mk(AS_U1, 8'hAA, 1'b0, 1'b0, 1'b0);
                    3'd1:    ent = mk(AS_U2, 8'h55, 1'b0, 1'b0, 1'b0);
                    3'd2:    ent = mk(AS_U1, 8'h80, 1'b0, 1'b0, 1'b0);
                    3'd3:    ent = mk(AS_U1, 8'hAA, 1'b0, 1'b0, 1'b0);
                    3'd4:    ent = mk(AS_U2, 8'h55, 1'b0, 1'b0, 1'b0);
                    default: begin
                        if (op == OP_SECTOR_ERASE)
                            ent = mk(AS_TGT, 8'h30, 1'b0, 1'b0, 1'b1);
                        else
                            ent = mk(AS_U1, 8'h10, 1'b0, 1'b0, 1'b1);
                    end
                endcase
            end
            OP_BYP_ENTER: begin
                case (idx)
                    3'd0:    ent = mk(AS_U1, 8'hAA, 1'b0, 1'b0, 1'b0);
                    3'd1:    ent = mk(AS_U2, 8'h55, 1'b0, 1'b0, 1'b0);
                    default: ent = mk(AS_U1, 8'h20, 1'b0, 1'b0, 1'b1);
                endcase
            end
            OP_BYP_PROGRAM: begin
                if (idx == 3'd0) ent = mk(AS_ZERO, 8'hA0, 1'b0, 1'b0, 1'b0);
                else             ent = mk(AS_TGT,  8'h00, 1'b1, 1'b0, 1'b1);
            end
            OP_BYP_EXIT: begin
                if (idx == 3'd0) ent = mk(AS_ZERO, 8'h90, 1'b0, 1'b0, 1'b0);
                else             ent = mk(AS_ZERO, 8'h00, 1'b0, 1'b0, 1'b1);
            end
            OP_IDENTIFY: begin
                case (idx)
                    3'd0:    ent = mk(AS_U1,  8'hAA, 1'b0, 1'b0, 1'b0);
                    3'd1:    ent = mk(AS_U2,  8'h55, 1'b0, 1'b0, 1'b0);
                    3'd2:    ent = mk(AS_U1,  8'h90, 1'b0, 1'b0, 1'b0);
                    default: ent = mk(AS_TGT, 8'h00, 1'b0, 1'b1, 1'b1);
                endcase
            end
            default: ent = mk(AS_ZERO, 8'h00, 1'b0, 1'b0, 1'b1);
        endcase
    end

    // Address mux: the width mode picks the unlock pair
    always_comb begin
        unique case (ent.asel)
            AS_U1:   step_addr = word_mode ? U1W : U1B;
            AS_U2:   step_addr = word_mode ? U2W : U2B;
            AS_TGT:  step_addr = tgt_addr;
            default: step_addr = '0;
        endcase
        step_data = ent.use_tgt ? tgt_data : {{(DW-8){1'b0}}, ent.cmd};
        step_read = ent.rd;
        step_last = ent.last;
    end

endmodule

// File: rtl/flash_cycle_timer.sv
module flash_cycle_timer
    import flash_seq_pkg::*;
#(
    parameter int SETUP_CLKS = 2,
    parameter int PULSE_CLKS = 3,
    parameter int HOLD_CLKS  = 1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    output phase_e phase,
    output logic   pulse_last,
    output logic   cyc_end
);

    localparam int MAXC = (SETUP_CLKS > PULSE_CLKS)
                        ? ((SETUP_CLKS > HOLD_CLKS) ? SETUP_CLKS : HOLD_CLKS)
                        : ((PULSE_CLKS > HOLD_CLKS) ? PULSE_CLKS : HOLD_CLKS);
    localparam int CW = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CW-1:0] SETUP_END = CW'(SETUP_CLKS - 1);
    localparam logic [CW-1:0] PULSE_END = CW'(PULSE_CLKS - 1);
    localparam logic [CW-1:0] HOLD_END  = CW'(HOLD_CLKS - 1);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        unique case (tmr_q.ph)
            PH_IDLE: begin
                if (start) begin
                    tmr_d.ph  = PH_SETUP;
                    tmr_d.cnt = '0;
                end
            end
            PH_SETUP: begin
                if (tmr_q.cnt == SETUP_END) begin
                    tmr_d.ph  = PH_PULSE;
                    tmr_d.cnt = '0;
                end else begin
                    tmr_d.cnt = tmr_q.cnt + 1'b1;
                end
            end
            PH_PULSE: begin
                if (tmr_q.cnt == PULSE_END) begin
                    tmr_d.ph  = PH_HOLD;
                    tmr_d.cnt = '0;
                end else begin
                    tmr_d.cnt = tmr_q.cnt + 1'b1;
                end
            end
            default: begin
                if (tmr_q.cnt == HOLD_END) begin
                    tmr_d.ph  = start ? PH_SETUP : PH_IDLE;
                    tmr_d.cnt = '0;
                end else begin
                    tmr_d.cnt = tmr_q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q.ph  <= PH_IDLE;
            tmr_q.cnt <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign phase      = tmr_q.ph;
    assign pulse_last = (tmr_q.ph == PH_PULSE) && (tmr_q.cnt == PULSE_END);
    assign cyc_end    = (tmr_q.ph == PH_HOLD)  && (tmr_q.cnt == HOLD_END);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int AW         = 20,
    parameter int DW         = 16,
    parameter int SETUP_CLKS = 2,
    parameter int PULSE_CLKS = 3,
    parameter int HOLD_CLKS  = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [3:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic          word_mode,
    output logic          req_ready,
    output logic          done,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_dout,
    input  logic [DW-1:0] fl_din,
    output logic          fl_drive,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n
);

    typedef struct packed {
        logic              busy;
        op_e               op;
        logic [STEP_W-1:0] idx;
        logic              wmode;
        logic [AW-1:0]     addr;
        logic [DW-1:0]     data;
        logic              done;
        logic [DW-1:0]     rdat;
    } seq_t;

    seq_t seq_d, seq_q;

    logic          start;
    phase_e        phase;
    logic          pulse_last;
    logic          cyc_end;
    logic [AW-1:0] step_addr;
    logic [DW-1:0] step_data;
    logic          step_read;
    logic          step_last;

    flash_seq_table #(.AW(AW), .DW(DW)) u_table (
        .op        (seq_q.op),
        .idx       (seq_q.idx),
        .word_mode (seq_q.wmode),
        .tgt_addr  (seq_q.addr),
        .tgt_data  (seq_q.data),
        .step_addr (step_addr),
        .step_data (step_data),
        .step_read (step_read),
        .step_last (step_last)
    );

    flash_cycle_timer #(
        .SETUP_CLKS (SETUP_CLKS),
        .PULSE_CLKS (PULSE_CLKS),
        .HOLD_CLKS  (HOLD_CLKS)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .phase      (phase),
        .pulse_last (pulse_last),
        .cyc_end    (cyc_end)
    );

    // Sequencer: accept, step through the table, finish with done
    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        start      = 1'b0;
        if (!seq_q.busy) begin
            if (req_valid && op_known(req_op)) begin
                seq_d.busy  = 1'b1;
                seq_d.op    = op_e'(req_op);
                seq_d.idx   = '0;
                seq_d.wmode = word_mode;
                seq_d.addr  = req_addr;
                seq_d.data  = req_data;
                start       = 1'b1;
            end
        end else begin
            if (pulse_last && step_read)
                seq_d.rdat = fl_din;
            if (cyc_end) begin
                if (step_last) begin
                    seq_d.busy = 1'b0;
                    seq_d.done = 1'b1;
                end else begin
                    seq_d.idx = seq_q.idx + 1'b1;
                    start     = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.busy  <= 1'b0;
            seq_q.op    <= OP_RESET;
            seq_q.idx   <= '0;
            seq_q.wmode <= 1'b0;
            seq_q.addr  <= '0;
            seq_q.data  <= '0;
            seq_q.done  <= 1'b0;
            seq_q.rdat  <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready = !seq_q.busy;
    assign done      = seq_q.done;
    assign rd_data   = seq_q.rdat;
    assign fl_addr   = seq_q.busy ? step_addr : '0;
    assign fl_dout   = seq_q.busy ? step_data : '0;
    assign fl_drive  = seq_q.busy && !step_read;
    assign fl_ce_n   = (phase == PH_IDLE);
    assign fl_we_n   = !((phase == PH_PULSE) && !step_read);
    assign fl_oe_n   = !((phase == PH_PULSE) && step_read);

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          done,
    input logic [AW-1:0] fl_addr,
    input logic [DW-1:0] fl_dout,
    input logic          fl_drive,
    input logic          fl_ce_n,
    input logic          fl_we_n,
    input logic          fl_oe_n
);

    assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_we_n && !fl_oe_n));

    assert_bus_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> !fl_drive);

    assert_we_needs_ce_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> !fl_ce_n);

    assert_ce_before_we_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_we_n) |-> $past(!fl_ce_n));

    assert_stable_in_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dout)));

    assert_hold_after_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_we_n) |-> (!fl_ce_n && $stable(fl_addr) && $stable(fl_dout)));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (fl_ce_n && fl_we_n && fl_oe_n));

endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;

    localparam int S = 2;
    localparam int P = 3;
    localparam int H = 1;
    localparam int L = S + P + H;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_op = 4'd0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_data = '0;
    logic        word_mode = 1'b0;
    logic        req_ready, done, fl_drive, fl_ce_n, fl_we_n, fl_oe_n;
    logic [15:0] rd_data, fl_dout, fl_din;
    logic [19:0] fl_addr;

    always #2.5 clk = ~clk;

    assign fl_din = fl_addr[15:0] ^ 16'h5A5A;

    flash_cmd_seq #(.AW(20), .DW(16), .SETUP_CLKS(S), .PULSE_CLKS(P), .HOLD_CLKS(H)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .word_mode(word_mode),
        .req_ready(req_ready), .done(done), .rd_data(rd_data), .fl_addr(fl_addr),
        .fl_dout(fl_dout), .fl_din(fl_din), .fl_drive(fl_drive), .fl_ce_n(fl_ce_n),
        .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Behavioural reference model: a queue of expected bus cycles
    typedef struct {
        logic [19:0] a;
        logic [15:0] d;
        bit          rd;
    } mstep_t;

    mstep_t      mq[$];
    bit          m_busy = 0;
    bit          m_done = 0;
    int          m_t = 0;
    int          m_op = 0;
    logic [15:0] m_rd = '0;
    bit          started = 0;

    function automatic string optag(input int op);
        case (op)
            1:       return "R2";
            2:       return "R4";
            3:       return "R5";
            4, 5, 6: return "R6";
            9:       return "R8";
            default: return "R7";
        endcase
    endfunction

    function automatic void add(input logic [19:0] a, input logic [15:0] d, input bit rd);
        mstep_t s;
        s.a = a; s.d = d; s.rd = rd;
        mq.push_back(s);
    endfunction

    function automatic void build(input int op, input logic [19:0] a,
                                  input logic [15:0] d, input bit wm);
        logic [19:0] u1, u2;
        u1 = wm ? 20'h555 : 20'hAAA;
        u2 = wm ? 20'h2AA : 20'h555;
        mq.delete();
        case (op)
            0: add(0, 16'hF0, 0);
            1: begin add(u1, 16'hAA, 0); add(u2, 16'h55, 0); add(u1, 16'hA0, 0); add(a, d, 0); end
            2, 3: begin
                add(u1, 16'hAA, 0); add(u2, 16'h55, 0); add(u1, 16'h80, 0);
                add(u1, 16'hAA, 0); add(u2, 16'h55, 0);
                if (op == 2) add(u1, 16'h10, 0); else add(a, 16'h30, 0);
            end
            4: begin add(u1, 16'hAA, 0); add(u2, 16'h55, 0); add(u1, 16'h20, 0); end
            5: begin add(0, 16'hA0, 0); add(a, d, 0); end
            6: begin add(0, 16'h90, 0); add(0, 16'h00, 0); end
            7: add(0, 16'hB0, 0);
            8: add(0, 16'h30, 0);
            default: begin add(u1, 16'hAA, 0); add(u2, 16'h55, 0); add(u1, 16'h90, 0); add(a, 16'h0, 1); end
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_t = 0; m_rd = '0;
        end else begin
            started = 1;
            m_done = 0;
            if (m_busy) begin
                if (mq[m_t / L].rd && (m_t % L) == S + P - 1)
                    m_rd = mq[m_t / L].a[15:0] ^ 16'h5A5A;
                if (m_t == mq.size() * L - 1) begin
                    m_busy = 0; m_done = 1;
                end else begin
                    m_t++;
                end
            end else if (req_valid && req_op <= 4'd9) begin
                build(int'(req_op), req_addr, req_data, word_mode);
                m_op = int'(req_op);
                m_busy = 1; m_t = 0;
            end
        end
    end

    // Per-clock comparison away from the active edge
    int  n_wfall = 0;
    int  n_rfall = 0;
    int  n_ce_low = 0;
    bit  prev_we = 1, prev_oe = 1;

    always @(negedge clk) begin
        if (started) begin
            bit          pulse, rd;
            int          r;
            logic [19:0] ea;
            logic [15:0] ed;
            string       tg;
            pulse = 0; rd = 0; ea = '0; ed = '0;
            tg = m_busy ? optag(m_op) : "R1";
            if (m_busy) begin
                r     = m_t % L;
                pulse = (r >= S) && (r < S + P);
                rd    = mq[m_t / L].rd;
                ea    = mq[m_t / L].a;
                ed    = mq[m_t / L].d;
            end
            chk(fl_ce_n == !m_busy, "R9", "ce_n", fl_ce_n, !m_busy);
            chk(fl_we_n == !(pulse && !rd), "R9", "we_n", fl_we_n, !(pulse && !rd));
            chk(fl_oe_n == !(pulse && rd), "R8", "oe_n", fl_oe_n, !(pulse && rd));
            chk(fl_drive == (m_busy && !rd), "R8", "drive", fl_drive, m_busy && !rd);
            chk(fl_addr == ea, {"R3 ", tg}, "addr", fl_addr, ea);
            chk(fl_dout == ed, tg, "dout", fl_dout, ed);
            chk(done == m_done, "R11", "done", done, m_done);
            chk(req_ready == !m_busy, "R10", "ready", req_ready, !m_busy);
            chk(rd_data == m_rd, "R8", "rd_data", rd_data, m_rd);
            if (prev_we && !fl_we_n) n_wfall++;
            if (prev_oe && !fl_oe_n) n_rfall++;
            if (!fl_ce_n) n_ce_low++;
            prev_we = fl_we_n;
            prev_oe = fl_oe_n;
        end
    end

    task automatic run(input logic [3:0] op, input logic [19:0] a, input logic [15:0] d,
                       input bit wm, input int exp_w, input int exp_r,
                       input string tag, input bit poke);
        int g;
        @(negedge clk);
        req_valid = 1; req_op = op; req_addr = a; req_data = d; word_mode = wm;
        n_wfall = 0; n_rfall = 0;
        @(negedge clk);
        req_valid = 0; word_mode = !wm; req_addr = ~a; req_data = ~d;
        if (poke) begin
            // R10: requests while busy must be ignored
            repeat (2) @(negedge clk);
            req_valid = 1; req_op = 4'd0;
            repeat (3) @(negedge clk);
            req_valid = 0;
        end
        g = 0;
        while (!done && g < 300) begin
            @(negedge clk);
            g++;
        end
        chk(done == 1'b1, tag, "done seen", done, 1);
        chk(n_wfall == exp_w, tag, "write strobes", n_wfall, exp_w);
        chk(n_rfall == exp_r, tag, "read strobes", n_rfall, exp_r);
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=%0d expected<100000", wd);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values while reset is held
        chk(fl_ce_n && fl_we_n && fl_oe_n, "R1", "strobes in reset", {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);
        chk(!done && req_ready, "R1", "done/ready in reset", {done, req_ready}, 2'b01);
        chk(fl_addr == 0 && fl_dout == 0, "R1", "bus in reset", fl_addr, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk(fl_ce_n && req_ready, "R1", "idle after reset", {fl_ce_n, req_ready}, 2'b11);

        run(4'd1, 20'h12345, 16'hBEEF, 0, 4, 0, "R2", 0);   // program, byte mode
        run(4'd1, 20'h0ABCD, 16'h1234, 1, 4, 0, "R3", 0);   // program, word mode
        run(4'd2, 20'h00000, 16'h0000, 0, 6, 0, "R4", 0);   // chip erase
        run(4'd3, 20'h7C000, 16'h0000, 1, 6, 0, "R5", 0);   // sector erase, word
        run(4'd3, 20'h3E000, 16'h0000, 0, 6, 0, "R10", 1);  // busy-ignore
        run(4'd4, 20'h00000, 16'h0000, 0, 3, 0, "R6", 0);   // bypass enter
        run(4'd5, 20'h00100, 16'hCAFE, 0, 2, 0, "R6", 0);   // bypass program
        run(4'd5, 20'hFFFFF, 16'hFFFF, 1, 2, 0, "R6", 0);
        run(4'd6, 20'h00000, 16'h0000, 0, 2, 0, "R6", 0);   // bypass exit
        run(4'd0, 20'h55555, 16'h0000, 0, 1, 0, "R7", 0);   // reset
        run(4'd7, 20'h00000, 16'h0000, 1, 1, 0, "R7", 0);   // suspend
        run(4'd8, 20'h00000, 16'h0000, 0, 1, 0, "R7", 0);   // resume

        run(4'd9, 20'h00002, 16'h0000, 1, 3, 1, "R8", 0);   // identify, word
        chk(rd_data == (16'h0002 ^ 16'h5A5A), "R8", "identify data word", rd_data, 16'h0002 ^ 16'h5A5A);
        run(4'd9, 20'h00004, 16'h0000, 0, 3, 1, "R8", 0);   // identify, byte
        chk(rd_data == (16'h0004 ^ 16'h5A5A), "R8", "identify data byte", rd_data, 16'h0004 ^ 16'h5A5A);

        // R10: unused codes start nothing
        for (int c = 10; c < 16; c++) begin
            @(negedge clk);
            req_valid = 1; req_op = 4'(c);
            @(negedge clk);
            req_valid = 0;
            n_ce_low = 0;
            repeat (8) @(negedge clk);
            chk(n_ce_low == 0, "R10", "unused code bus activity", n_ce_low, 0);
        end
        chk(rd_data == (16'h0004 ^ 16'h5A5A), "R8", "rd_data held", rd_data, 16'h0004 ^ 16'h5A5A);

        // R11: a request presented in the done clock is accepted
        run(4'd7, 20'h0, 16'h0, 0, 1, 0, "R11", 0);
        req_valid = 1; req_op = 4'd8;
        @(negedge clk);
        req_valid = 0;
        chk(fl_ce_n == 1'b0, "R11", "accepted during done", fl_ce_n, 0);
        repeat (L + 4) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule